// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, one frame at a time, whether a received Ethernet frame is meant for this station. The receive path presents the 48-bit destination address with a one-cycle strobe. One clock later the filter returns a verdict: accept or reject. An accepted frame may also carry a class flag, either multicast or broadcast.

The verdict comes from three mode inputs plus a table of sixteen station addresses. Each table slot has its own enable bit. The modes are: unicast promiscuous, take every multicast, and take broadcast.

Software fills the table sixteen bits at a time. Software can read it back through an entry pointer and three 16-bit read-back words. The read-back words show table contents only while the controller's reset-mode flag is asserted.

Top module: `eth_addr_filter`

## Requirements
- R1: After reset, every result output is 0, every table entry reads back as zero, and every enable bit is 0. With all modes off, a lookup of any address is therefore rejected.
- R2: A lookup strobed on `dst_valid` in one cycle gives `res_valid` = 1 on the next clock edge, for exactly one cycle. In that cycle exactly one of `res_accept` and `res_reject` is 1.
- R3: With `mode_promisc` = 1, an address whose byte 0 (`dst_addr[7:0]`, the first byte on the wire) has bit 0 clear is accepted. Neither class flag is set.
- R4: With `mode_all_mcast` = 1, an address whose byte 0 has bit 0 set is accepted with `res_mcast` = 1 and `res_bcast` = 0.
- R5: With `mode_bcast` = 1, the all-ones address is accepted with `res_bcast` = 1. This test is applied only after the multicast test, so when `mode_all_mcast` is also on, the all-ones address gets `res_mcast` and not `res_bcast`. An address that is not all ones never gets `res_bcast`.
- R6: If no mode test accepts the address, it is accepted only when an entry whose enable bit is 1 equals all six bytes. Such a match sets no class flag. A disabled entry or a partial match gives a reject.
- R7: A write with `tbl_wr_word` = w (0..2) to entry `tbl_wr_entry` loads address byte 2w from `tbl_wr_data[7:0]` and byte 2w+1 from `tbl_wr_data[15:8]`. A write to `ena_wr_data` bit i enables entry i.
- R8: With `rst_mode` = 1, `rb_word`k (k = 0..2) returns byte 2k+1 of entry `rb_ptr` in bits 15:8 and byte 2k in bits 7:0.
- R9: With `rst_mode` = 0, all three read-back words are zero.
- R10: A table write or an enable-mask write presented in a cycle where `dst_valid` = 1 is discarded.
- R11: Promiscuous mode does not accept addresses whose byte 0 bit 0 is set. With only `mode_promisc` on and no matching entry, such an address is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dst_valid | input | 1 | Lookup strobe |
| dst_addr | input | 48 | Destination address, byte k at bits 8k+7:8k |
| mode_promisc | input | 1 | Accept every unicast address |
| mode_all_mcast | input | 1 | Accept every multicast address |
| mode_bcast | input | 1 | Accept the all-ones address |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_entry | input | 4 | Entry index for the table write |
| tbl_wr_word | input | 2 | Word index inside the entry (0..2) |
| tbl_wr_data | input | 16 | Byte pair to store |
| ena_wr_en | input | 1 | Enable mask write strobe |
| ena_wr_data | input | 16 | New enable mask, one bit per entry |
| rst_mode | input | 1 | Controller reset-mode flag gating read-back |
| rb_ptr | input | 4 | Entry selected for read-back |
| rb_word0 | output | 16 | Bytes 1:0 of the selected entry |
| rb_word1 | output | 16 | Bytes 3:2 of the selected entry |
| rb_word2 | output | 16 | Bytes 5:4 of the selected entry |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_reject | output | 1 | Frame rejected |
| res_mcast | output | 1 | Accepted as multicast |
| res_bcast | output | 1 | Accepted as broadcast |

## Verification
The assertions assume the mode inputs and `dst_addr` stay steady for the whole cycle in which `dst_valid` is sampled. They also assume reads only rely on table writes that land in cycles without a strobe.

The bench drives every input at the falling edge and holds modes constant around each lookup. It deliberately overlaps a write with a strobe only in the scenario that checks such writes are discarded. Verdicts are sampled at the falling edge after the registering clock edge.

// File: rtl/afilt_pkg.sv
`timescale 1ns/1ps
package afilt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SRC_REJECT  = 3'd0,
    SRC_PROMISC = 3'd1,
    SRC_MCAST   = 3'd2,
    SRC_BCAST   = 3'd3,
    SRC_CAM     = 3'd4
  } afilt_src_e;

  typedef struct packed {
    logic accept;
    logic reject;
    logic mcast;
    logic bcast;
  } afilt_res_t;
endpackage

// File: rtl/afilt_store.sv
`timescale 1ns/1ps
module afilt_store #(
  parameter int ENTRIES     = 16,
  parameter int ADDR_BYTES  = 6,
  parameter int WORD_W      = 16,
  localparam int ADDR_W      = ADDR_BYTES * afilt_pkg::BYTE_W,
  localparam int ENTRY_WORDS = ADDR_W / WORD_W,
  localparam int PTR_W       = $clog2(ENTRIES),
  localparam int WSEL_W      = (ENTRY_WORDS > 1) ? $clog2(ENTRY_WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      busy,
  input  logic                      wr_en,
  input  logic [PTR_W-1:0]          wr_entry,
  input  logic [WSEL_W-1:0]         wr_word,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      ena_wr_en,
  input  logic [ENTRIES-1:0]        ena_wr_data,
  input  logic                      rst_mode,
  input  logic [PTR_W-1:0]          rb_ptr,
  output logic [ENTRIES*ADDR_W-1:0] tbl_flat,
  output logic [ENTRIES-1:0]        ena_mask,
  output logic [ADDR_W-1:0]         rb_entry
);
  logic wr_ok;
  logic ena_ok;
  logic [ENTRIES-1:0] ena_d;
  logic [ENTRIES-1:0] ena_q;

  assign wr_ok  = wr_en & ~busy;
  assign ena_ok = ena_wr_en & ~busy;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    for (genvar w = 0; w < ENTRY_WORDS; w++) begin : g_word
      logic             sel;
      logic [WORD_W-1:0] word_d;
      logic [WORD_W-1:0] word_q;

      assign sel = wr_ok && (wr_entry == PTR_W'(e)) && (wr_word == WSEL_W'(w));

      always_comb begin
        word_d = word_q;
        if (sel) word_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else if (sel) word_q <= word_d;
      end

      assign tbl_flat[(e*ENTRY_WORDS + w)*WORD_W +: WORD_W] = word_q;
    end
  end

  always_comb begin
    ena_d = ena_q;
    if (ena_ok) ena_d = ena_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ena_q <= '0;
    else if (ena_ok) ena_q <= ena_d;
  end

  assign ena_mask = ena_q;

  always_comb begin
    rb_entry = '0;
    if (rst_mode && (32'(rb_ptr) < ENTRIES))
      rb_entry = tbl_flat[32'(rb_ptr)*ADDR_W +: ADDR_W];
  end

  // R10
  tbl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tbl_flat) && $stable(ena_q)));
endmodule

// File: rtl/afilt_match.sv
`timescale 1ns/1ps
module afilt_match #(
  parameter int ENTRIES    = 16,
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W    = ADDR_BYTES * afilt_pkg::BYTE_W
) (
  input  logic [ENTRIES*ADDR_W-1:0] tbl_flat,
  input  logic [ENTRIES-1:0]        ena_mask,
  input  logic [ADDR_W-1:0]         addr,
  output logic                      cam_hit
);
  logic [ENTRIES-1:0] hit_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hit_vec[e] = ena_mask[e] && (tbl_flat[e*ADDR_W +: ADDR_W] == addr);
  end

  assign cam_hit = |hit_vec;
endmodule

// File: rtl/afilt_decide.sv
`timescale 1ns/1ps
module afilt_decide #(
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W    = ADDR_BYTES * afilt_pkg::BYTE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dst_valid,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   mode_promisc,
  input  logic                   mode_all_mcast,
  input  logic                   mode_bcast,
  input  logic                   cam_hit,
  output logic                   res_valid,
  output afilt_pkg::afilt_res_t  res
);
  import afilt_pkg::*;

  afilt_src_e src;
  afilt_res_t res_d;
  afilt_res_t res_q;
  logic       valid_q;
  logic       grp_bit;

  assign grp_bit = addr[0];

  always_comb begin
    if (mode_promisc && !grp_bit)        src = SRC_PROMISC;
    else if (mode_all_mcast && grp_bit)  src = SRC_MCAST;
    else if (mode_bcast && (&addr))      src = SRC_BCAST;
    else if (cam_hit)                    src = SRC_CAM;
    else                                 src = SRC_REJECT;
  end

  always_comb begin
    res_d = '0;
    if (dst_valid) begin
      case (src)
        SRC_PROMISC: res_d.accept = 1'b1;
        SRC_CAM:     res_d.accept = 1'b1;
        SRC_MCAST:   begin res_d.accept = 1'b1; res_d.mcast = 1'b1; end
        SRC_BCAST:   begin res_d.accept = 1'b1; res_d.bcast = 1'b1; end
        default:     res_d.reject = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= dst_valid;
      res_q   <= res_d;
    end
  end

  assign res_valid = valid_q;
  assign res       = res_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> res_valid);
  // R2
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res.accept, res.reject}) == 1));
  // R5
  class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res.mcast, res.bcast}));
  // R3
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && mode_promisc && !addr[0]) |=> (res.accept && !res.mcast && !res.bcast));
  // R5
  mcast_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && mode_all_mcast && addr[0]) |=> (res.mcast && !res.bcast));
endmodule

// File: rtl/eth_addr_filter.sv
`timescale 1ns/1ps
module eth_addr_filter #(
  parameter int ENTRIES    = 16,
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 16,
  localparam int ADDR_W      = ADDR_BYTES * 8,
  localparam int ENTRY_WORDS = ADDR_W / WORD_W,
  localparam int PTR_W       = $clog2(ENTRIES),
  localparam int WSEL_W      = (ENTRY_WORDS > 1) ? $clog2(ENTRY_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dst_valid,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              mode_promisc,
  input  logic              mode_all_mcast,
  input  logic              mode_bcast,
  input  logic              tbl_wr_en,
  input  logic [PTR_W-1:0]  tbl_wr_entry,
  input  logic [WSEL_W-1:0] tbl_wr_word,
  input  logic [WORD_W-1:0] tbl_wr_data,
  input  logic              ena_wr_en,
  input  logic [ENTRIES-1:0] ena_wr_data,
  input  logic              rst_mode,
  input  logic [PTR_W-1:0]  rb_ptr,
  output logic [WORD_W-1:0] rb_word0,
  output logic [WORD_W-1:0] rb_word1,
  output logic [WORD_W-1:0] rb_word2,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_reject,
  output logic              res_mcast,
  output logic              res_bcast
);
  logic [1:0]                rst_sync_q;
  logic                      rst_n_int;
  logic [ENTRIES*ADDR_W-1:0] tbl_flat;
  logic [ENTRIES-1:0]        ena_mask;
  logic [ADDR_W-1:0]         rb_entry;
  logic                      cam_hit;
  afilt_pkg::afilt_res_t     res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  afilt_store #(.ENTRIES(ENTRIES), .ADDR_BYTES(ADDR_BYTES), .WORD_W(WORD_W)) i_store (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .busy       (dst_valid),
    .wr_en      (tbl_wr_en),
    .wr_entry   (tbl_wr_entry),
    .wr_word    (tbl_wr_word),
    .wr_data    (tbl_wr_data),
    .ena_wr_en  (ena_wr_en),
    .ena_wr_data(ena_wr_data),
    .rst_mode   (rst_mode),
    .rb_ptr     (rb_ptr),
    .tbl_flat   (tbl_flat),
    .ena_mask   (ena_mask),
    .rb_entry   (rb_entry)
  );

  afilt_match #(.ENTRIES(ENTRIES), .ADDR_BYTES(ADDR_BYTES)) i_match (
    .tbl_flat(tbl_flat),
    .ena_mask(ena_mask),
    .addr    (dst_addr),
    .cam_hit (cam_hit)
  );

  afilt_decide #(.ADDR_BYTES(ADDR_BYTES)) i_decide (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .dst_valid     (dst_valid),
    .addr          (dst_addr),
    .mode_promisc  (mode_promisc),
    .mode_all_mcast(mode_all_mcast),
    .mode_bcast    (mode_bcast),
    .cam_hit       (cam_hit),
    .res_valid     (res_valid),
    .res           (res)
  );

  assign rb_word0   = rb_entry[0*WORD_W +: WORD_W];
  assign rb_word1   = rb_entry[1*WORD_W +: WORD_W];
  assign rb_word2   = rb_entry[2*WORD_W +: WORD_W];
  assign res_accept = res.accept;
  assign res_reject = res.reject;
  assign res_mcast  = res.mcast;
  assign res_bcast  = res.bcast;

  // R9
  rb_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rst_mode |-> (rb_word0 == '0 && rb_word1 == '0 && rb_word2 == '0));
endmodule

// File: tb/test_eth_addr_filter.sv
`timescale 1ns/1ps
module test_eth_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dst_valid;
  logic [47:0] dst_addr;
  logic        mode_promisc, mode_all_mcast, mode_bcast;
  logic        tbl_wr_en;
  logic [3:0]  tbl_wr_entry;
  logic [1:0]  tbl_wr_word;
  logic [15:0] tbl_wr_data;
  logic        ena_wr_en;
  logic [15:0] ena_wr_data;
  logic        rst_mode;
  logic [3:0]  rb_ptr;
  logic [15:0] rb_word0, rb_word1, rb_word2;
  logic        res_valid, res_accept, res_reject, res_mcast, res_bcast;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  eth_addr_filter i_eth_addr_filter (
    .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast), .mode_bcast(mode_bcast),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_entry(tbl_wr_entry), .tbl_wr_word(tbl_wr_word),
    .tbl_wr_data(tbl_wr_data), .ena_wr_en(ena_wr_en), .ena_wr_data(ena_wr_data),
    .rst_mode(rst_mode), .rb_ptr(rb_ptr), .rb_word0(rb_word0), .rb_word1(rb_word1),
    .rb_word2(rb_word2), .res_valid(res_valid), .res_accept(res_accept),
    .res_reject(res_reject), .res_mcast(res_mcast), .res_bcast(res_bcast)
  );

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_modes(input logic p, input logic m, input logic b);
    @(negedge clk);
    mode_promisc = p; mode_all_mcast = m; mode_bcast = b;
  endtask

  task automatic lookup(input string req, input logic [47:0] a,
                        input logic acc, input logic mc, input logic bc);
    @(negedge clk);
    dst_addr  = a;
    dst_valid = 1'b1;
    @(negedge clk);
    dst_valid = 1'b0;
    check(req, {59'd0, res_valid, res_accept, res_reject, res_mcast, res_bcast},
          {59'd0, 1'b1, acc, !acc, mc, bc});
    @(negedge clk);
    check("R2 single-cycle valid", {63'd0, res_valid}, 64'd0);
  endtask

  task automatic write_word(input logic [3:0] e, input logic [1:0] w, input logic [15:0] d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_entry = e; tbl_wr_word = w; tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic load_entry(input logic [3:0] e, input logic [47:0] a);
    for (int w = 0; w < 3; w++) write_word(e, 2'(w), a[w*16 +: 16]);
  endtask

  task automatic write_mask(input logic [15:0] m);
    @(negedge clk);
    ena_wr_en = 1'b1; ena_wr_data = m;
    @(negedge clk);
    ena_wr_en = 1'b0;
  endtask

  task automatic readback(input string req, input logic [3:0] p, input logic rm,
                          input logic [47:0] exp);
    @(negedge clk);
    rb_ptr = p; rst_mode = rm;
    #1;
    check(req, {16'd0, rb_word2, rb_word1, rb_word0}, {16'd0, exp});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {59'd0, res_valid, res_accept, res_reject, res_mcast, res_bcast}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outputs after reset", {59'd0, res_valid, res_accept, res_reject, res_mcast, res_bcast}, 64'd0);
    readback("R1 entry 0 cleared", 4'd0, 1'b1, 48'd0);
    readback("R1 entry 15 cleared", 4'd15, 1'b1, 48'd0);
    lookup("R1 mask cleared rejects", 48'd0, 1'b0, 1'b0, 1'b0);
  endtask

  localparam logic [47:0] A3  = 48'h5544_3322_1102;
  localparam logic [47:0] A15 = 48'hF0E0_D0C0_B0A0;

  task automatic t_load_readback;
    load_entry(4'd3, A3);
    load_entry(4'd15, A15);
    readback("R7 R8 entry 3 words", 4'd3, 1'b1, 48'h5544_3322_1102);
    readback("R8 entry 15 words", 4'd15, 1'b1, A15);
    write_word(4'd3, 2'd1, 16'hBEEF);
    readback("R7 single word replaced", 4'd3, 1'b1, 48'h5544_BEEF_1102);
    write_word(4'd3, 2'd1, 16'h3322);
    readback("R9 hidden outside reset mode", 4'd3, 1'b0, 48'd0);
  endtask

  task automatic t_cam;
    set_modes(1'b0, 1'b0, 1'b0);
    lookup("R6 disabled entry rejects", A3, 1'b0, 1'b0, 1'b0);
    write_mask(16'h0008);
    lookup("R6 enabled entry accepts", A3, 1'b1, 1'b0, 1'b0);
    lookup("R6 last byte differs rejects", mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56), 1'b0, 1'b0, 1'b0);
    lookup("R6 first byte differs rejects", mk(8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 1'b0, 1'b0, 1'b0);
    lookup("R6 entry 15 still disabled", A15, 1'b0, 1'b0, 1'b0);
    write_mask(16'h8008);
    lookup("R6 entry 15 enabled", A15, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_promisc;
    set_modes(1'b1, 1'b0, 1'b0);
    lookup("R3 promisc unicast", mk(8'h04, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 1'b1, 1'b0, 1'b0);
    lookup("R11 promisc skips multicast", mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01), 1'b0, 1'b0, 1'b0);
    lookup("R11 promisc skips broadcast", 48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mcast;
    set_modes(1'b0, 1'b1, 1'b0);
    lookup("R4 all-multicast accepts", mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01), 1'b1, 1'b1, 1'b0);
    lookup("R4 unicast not multicast", mk(8'h04, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 1'b0, 1'b0, 1'b0);
    set_modes(1'b0, 1'b0, 1'b0);
    lookup("R4 mode off rejects", mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01), 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bcast;
    set_modes(1'b0, 1'b0, 1'b1);
    lookup("R5 broadcast accepts", 48'hFFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1);
    lookup("R5 near-broadcast rejects", mk(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFE), 1'b0, 1'b0, 1'b0);
    set_modes(1'b0, 1'b1, 1'b1);
    lookup("R5 multicast wins over broadcast", 48'hFFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0);
    set_modes(1'b0, 1'b0, 1'b0);
    lookup("R5 mode off rejects broadcast", 48'hFFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_busy_write;
    @(negedge clk);
    dst_addr = A3; dst_valid = 1'b1;
    tbl_wr_en = 1'b1; tbl_wr_entry = 4'd3; tbl_wr_word = 2'd0; tbl_wr_data = 16'hABCD;
    ena_wr_en = 1'b1; ena_wr_data = 16'h0000;
    @(negedge clk);
    dst_valid = 1'b0; tbl_wr_en = 1'b0; ena_wr_en = 1'b0;
    check("R10 lookup during write", {62'd0, res_valid, res_accept}, 64'd3);
    readback("R10 table write dropped", 4'd3, 1'b1, A3);
    lookup("R10 mask write dropped", A3, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    dst_valid = 0; dst_addr = '0; mode_promisc = 0; mode_all_mcast = 0; mode_bcast = 0;
    tbl_wr_en = 0; tbl_wr_entry = '0; tbl_wr_word = '0; tbl_wr_data = '0;
    ena_wr_en = 0; ena_wr_data = '0; rst_mode = 0; rb_ptr = '0;
    t_reset();
    t_load_readback();
    t_cam();
    t_promisc();
    t_mcast();
    t_bcast();
    t_busy_write();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule